// File: doc/BRIEF.md
# Sequential 16x16 Multiplier Built on One 8x8 Product Unit

This block forms the 32-bit product of two 16-bit operands over several clock cycles, using a single unsigned byte-by-byte multiplier. A start pulse captures both operands and a mode flag. The controller then steps the shared multiplier through the four byte pairings and accumulates each partial product into a four-byte result register. The low pairing and the high pairing are written straight into the lower and upper halves. The two cross pairings are added in at a weight of 2^8, with the carry running up to the top byte.

When the mode flag asks for two's complement, up to two correction steps follow. A negative B causes all of A to be subtracted from the upper result half. After that, a negative A causes all of B to be subtracted from the upper half. A correction step whose sign bit is clear is skipped. The result stays on the output until the next accepted start. A one-cycle done pulse marks the cycle in which the output holds the final product.

The controller has the states IDLE, LL (low×low), HH (high×high), LH (A-low×B-high), HL (A-high×B-low), FIX_B, FIX_A and DONE. Its transitions are as follows. IDLE→LL on start. LL→HH→LH→HL, one cycle each. HL→FIX_B when the mode is signed and B is negative. Otherwise HL→FIX_A when the mode is signed and A is negative. Otherwise HL→DONE. FIX_B→FIX_A when the mode is signed and A is negative, otherwise FIX_B→DONE. FIX_A→DONE. DONE→LL on start, otherwise DONE→IDLE.

Top module: `seq_mul16`

## Requirements
- R1: After reset, `result` is 0, `busy` is 0 and `done` is 0.
- R2: With `signed_mode` = 0 at start, `result` at done equals the unsigned product of `op_a` and `op_b`, as a 32-bit value.
- R3: With `signed_mode` = 1 at start, `result` at done equals the two's complement product of `op_a` and `op_b`, as a 32-bit value.
- R4: In unsigned mode, `busy` is high for exactly 4 cycles after the clock edge that accepts start, and `done` is high in the cycle that follows.
- R5: In signed mode, `busy` lasts 4 cycles plus one for each operand whose bit 15 is set, so 4 to 6 cycles.
- R6: Operands and mode are captured at the accepting edge. While `busy` is high, a start pulse and any change on `op_a`, `op_b` or `signed_mode` have no effect on the result.
- R7: `done` is high for exactly one cycle. Afterwards, `result` keeps the product until a new start is accepted.
- R8: Corner cases: 0x8000×0x8000 signed gives 0x40000000, 0xFFFF×0xFFFF gives 0xFFFE0001 unsigned and 0x00000001 signed, and a zero operand gives 0.
- R9: A start that is present in the done cycle is accepted, and a new operation begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Requests a multiply; accepted when busy is low |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned; captured at start |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| busy | output | 1 | High while partial-product or correction steps run |
| done | output | 1 | One-cycle pulse; result holds the final product |
| result | output | 32 | Product register |

## Verification
The assertions check on every cycle that `done` never lasts two cycles and that the captured operands do not move while busy. They also check that the result register is still while the block is idle, that the number of busy cycles matches the mode and the operand signs, and that the result equals a full-width reference product whenever done is high. Only the bench scenarios can show the following: that a start issued during a run is truly discarded, that back-to-back operations launched from the done cycle work, and that the corner-case operands give the exact values listed. These checks are made at the ports, on directed and seeded random operands in both modes.

// File: rtl/seq_mul16_pkg.sv
package seq_mul16_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_HH,
        ST_LH,
        ST_HL,
        ST_FIX_B,
        ST_FIX_A,
        ST_DONE
    } step_e;
endpackage

// File: rtl/byte_mul_unit.sv
module byte_mul_unit #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]   x,
    input  logic [BYTE_W-1:0]   y,
    output logic [2*BYTE_W-1:0] p
);
    localparam int PW = 2 * BYTE_W;

    logic [PW-1:0] x_ext;
    logic [PW-1:0] y_ext;

    assign x_ext = {{BYTE_W{1'b0}}, x};
    assign y_ext = {{BYTE_W{1'b0}}, y};
    assign p     = x_ext * y_ext;
endmodule

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl
    import seq_mul16_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  sgn_q,
    input  logic  a_neg,
    input  logic  b_neg,
    output step_e state,
    output logic  accept,
    output logic  busy,
    output logic  done
);
    step_e nxt;
    logic  fix_b_need;
    logic  fix_a_need;

    assign fix_b_need = sgn_q & b_neg;
    assign fix_a_need = sgn_q & a_neg;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = start ? ST_LL : ST_IDLE;
            ST_LL:    nxt = ST_HH;
            ST_HH:    nxt = ST_LH;
            ST_LH:    nxt = ST_HL;
            ST_HL:    nxt = fix_b_need ? ST_FIX_B :
                            (fix_a_need ? ST_FIX_A : ST_DONE);
            ST_FIX_B: nxt = fix_a_need ? ST_FIX_A : ST_DONE;
            ST_FIX_A: nxt = ST_DONE;
            ST_DONE:  nxt = start ? ST_LL : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_IDLE:  accept = start;
            ST_DONE:  begin done = 1'b1; accept = start; end
            ST_LL, ST_HH, ST_LH, ST_HL, ST_FIX_B, ST_FIX_A: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_LL));
endmodule

// File: rtl/mul_step_datapath.sv
module mul_step_datapath
    import seq_mul16_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                busy,
    input  step_e               state,
    input  logic                signed_mode,
    input  logic [2*BYTE_W-1:0] op_a,
    input  logic [2*BYTE_W-1:0] op_b,
    output logic [2*BYTE_W-1:0] a_q,
    output logic [2*BYTE_W-1:0] b_q,
    output logic                sgn_q,
    output logic                a_neg,
    output logic                b_neg,
    output logic [4*BYTE_W-1:0] res_q
);
    localparam int OW = 2 * BYTE_W;
    localparam int RW = 4 * BYTE_W;

    logic [BYTE_W-1:0] mx;
    logic [BYTE_W-1:0] my;
    logic [OW-1:0]     prod;
    logic [RW-1:0]     cross_add;
    logic [OW-1:0]     upper;

    assign a_neg     = a_q[OW-1];
    assign b_neg     = b_q[OW-1];
    assign cross_add = {{BYTE_W{1'b0}}, prod, {BYTE_W{1'b0}}};
    assign upper     = res_q[RW-1:OW];

    always_comb begin
        mx = a_q[BYTE_W-1:0];
        my = b_q[BYTE_W-1:0];
        unique case (state)
            ST_HH:   begin mx = a_q[OW-1:BYTE_W]; my = b_q[OW-1:BYTE_W]; end
            ST_LH:   begin mx = a_q[BYTE_W-1:0];  my = b_q[OW-1:BYTE_W]; end
            ST_HL:   begin mx = a_q[OW-1:BYTE_W]; my = b_q[BYTE_W-1:0];  end
            default: begin mx = a_q[BYTE_W-1:0];  my = b_q[BYTE_W-1:0];  end
        endcase
    end

    byte_mul_unit #(.BYTE_W(BYTE_W)) u_bmul (
        .x (mx),
        .y (my),
        .p (prod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
        end else if (accept) begin
            a_q   <= op_a;
            b_q   <= op_b;
            sgn_q <= signed_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            unique case (state)
                ST_LL:    res_q[OW-1:0]  <= prod;
                ST_HH:    res_q[RW-1:OW] <= prod;
                ST_LH,
                ST_HL:    res_q          <= res_q + cross_add;
                ST_FIX_B: res_q[RW-1:OW] <= upper - a_q;
                ST_FIX_A: res_q[RW-1:OW] <= upper - b_q;
                default:  res_q          <= res_q;
            endcase
        end
    end

    // R6
    operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> $stable(res_q));
endmodule

// File: rtl/seq_mul16.sv
module seq_mul16
    import seq_mul16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OP_W   = 2 * BYTE_W,
    parameter int RES_W  = 4 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    step_e           state;
    logic            accept;
    logic            sgn_q;
    logic            a_neg;
    logic            b_neg;
    logic [OP_W-1:0] a_q;
    logic [OP_W-1:0] b_q;

    mul_step_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .sgn_q  (sgn_q),
        .a_neg  (a_neg),
        .b_neg  (b_neg),
        .state  (state),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    mul_step_datapath #(.BYTE_W(BYTE_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .busy        (busy),
        .state       (state),
        .signed_mode (signed_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .a_q         (a_q),
        .b_q         (b_q),
        .sgn_q       (sgn_q),
        .a_neg       (a_neg),
        .b_neg       (b_neg),
        .res_q       (result)
    );

    logic [2:0]       lat_cnt;
    logic [2:0]       lat_exp;
    logic [RES_W-1:0] ua;
    logic [RES_W-1:0] ub;
    logic [RES_W-1:0] sa;
    logic [RES_W-1:0] sb;
    logic [RES_W-1:0] ref_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_cnt <= '0;
        else if (accept) lat_cnt <= '0;
        else if (busy)   lat_cnt <= lat_cnt + 3'd1;
    end

    assign lat_exp  = 3'd4 + {2'b0, sgn_q & a_neg} + {2'b0, sgn_q & b_neg};
    assign ua       = {{(RES_W-OP_W){1'b0}}, a_q};
    assign ub       = {{(RES_W-OP_W){1'b0}}, b_q};
    assign sa       = {{(RES_W-OP_W){a_q[OP_W-1]}}, a_q};
    assign sb       = {{(RES_W-OP_W){b_q[OP_W-1]}}, b_q};
    assign ref_prod = sgn_q ? (sa * sb) : (ua * ub);

    // R4 R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == lat_exp));

    // R2 R3
    product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == ref_prod));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (!busy && !done && result == '0));
endmodule

// File: tb/tb_seq_mul16.sv
`timescale 1ns/1ps
module tb_seq_mul16;
    localparam real CLK_HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    seq_mul16 dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b, input bit s);
        logic [31:0] xa, xb;
        xa = s ? {{16{a[15]}}, a} : {16'b0, a};
        xb = s ? {{16{b[15]}}, b} : {16'b0, b};
        return xa * xb;
    endfunction

    function automatic int ref_lat(input logic [15:0] a, input logic [15:0] b, input bit s);
        return 4 + (s ? (int'(a[15]) + int'(b[15])) : 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // At a negedge on entry; returns at the negedge where done is seen.
    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input bit s,
                         input bit interfere, input bit hold_chk);
        int cnt;
        logic [31:0] exp;
        exp = ref_mul(a, b, s);
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy && cnt < 10) begin
            cnt++;
            if (interfere) begin
                op_a = ~a; op_b = a ^ b; signed_mode = ~s;
                start = (cnt == 2);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(s ? "R5 busy length" : "R4 busy length", 32'(cnt), 32'(ref_lat(a, b, s)));
        check("R4 done after busy", {31'b0, done}, 32'd1);
        check(s ? "R3 signed product" : "R2 unsigned product", result, exp);
        if (interfere) check("R6 ignored start/inputs while busy", result, exp);
        if (hold_chk) begin
            @(negedge clk);
            check("R7 done one cycle", {31'b0, done}, 32'd0);
            check("R7 result held", result, exp);
        end
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 200000.0);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1
        check("R1 result at reset", result, 32'd0);
        check("R1 busy at reset", {31'b0, busy}, 32'd0);
        check("R1 done at reset", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 corner cases
        do_op(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1);
        check("R8 0x8000^2 signed", result, 32'h4000_0000);
        do_op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
        check("R8 0xFFFF^2 unsigned", result, 32'hFFFE_0001);
        do_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);
        check("R8 0xFFFF^2 signed", result, 32'h0000_0001);
        do_op(16'h0000, 16'hBEEF, 1'b1, 1'b0, 1'b1);
        check("R8 zero operand", result, 32'd0);
        do_op(16'h1234, 16'h0000, 1'b0, 1'b0, 1'b1);
        check("R8 zero operand", result, 32'd0);
        do_op(16'h7FFF, 16'h8000, 1'b1, 1'b0, 1'b1);
        do_op(16'h8000, 16'h0003, 1'b1, 1'b0, 1'b1);

        // R6 interference during busy
        do_op(16'hA5C3, 16'h5A3C, 1'b1, 1'b1, 1'b1);
        do_op(16'h00FF, 16'hFF00, 1'b0, 1'b1, 1'b1);

        // R9 back-to-back from the done cycle
        do_op(16'h1357, 16'h2468, 1'b0, 1'b0, 1'b0);
        do_op(16'hF00D, 16'hC0DE, 1'b1, 1'b0, 1'b0);
        check("R9 back-to-back product", result, ref_mul(16'hF00D, 16'hC0DE, 1'b1));
        @(negedge clk);

        // idle gap, then random mix (R2 R3)
        repeat (3) @(negedge clk);
        check("R7 result held while idle", result, ref_mul(16'hF00D, 16'hC0DE, 1'b1));
        for (int i = 0; i < 80; i++) begin
            logic [15:0] ra, rb;
            bit rs;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rs = 1'($urandom);
            do_op(ra, rb, rs, (i % 7) == 3, (i % 2) == 0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule